// File: doc/BRIEF.md
# Differential Crossbar Layer Post-Processor

This block is the digital back end of one neural-network layer built from two analog crossbars, one holding the positive part of every weight and one the negative part. After conversion, each neuron column arrives as two unsigned samples, one from each converter stream. For every neuron the block forms the signed difference of the two samples. It then adds that neuron's bias, saturates the sum and applies a rectifier. The results are streamed out in neuron order and drive the next layer's input converters.

For the last layer, a mode input switches the block into a reduction. Each rectified value is multiplied by a per-neuron output weight, and the products are summed with saturation into a single risk score. That score is the only output emitted for the vector.

The processing is a fixed-length pipeline. It accepts one neuron per cycle while the converters keep delivering, so the processing overlaps the conversion. Biases and output weights sit in two small register files. They are written through a simple write port before inference begins.

Top module: `xbar_diff_post`

## Requirements
- R1: A neuron pair is taken only in a cycle where `pos_valid` and `neg_valid` are both high. While only one stream presents valid, that stream's ready stays low and nothing is taken.
- R2: Samples are unsigned `SAMP_W`-bit codes. The difference positive minus negative is signed and `SAMP_W+1` bits wide, so it never wraps.
- R3: The per-neuron bias (signed, `SAMP_W+1` bits) is added to the difference, and the sum saturates to the signed `SAMP_W+1`-bit range instead of wrapping.
- R4: In hidden mode (`final_mode`=0), negative biased values are output as zero and non-negative ones pass unchanged.
- R5: In hidden mode, every taken pair produces exactly one output, in the order taken. `out_last` is high only on the output of neuron index `N_NEUR-1`, after which the index returns to 0.
- R6: In final mode (`final_mode`=1), a vector of `N_NEUR` pairs produces exactly one output, with `out_last` high. Its value is the running sum, starting from zero at index 0, of rectified value times output weight. The sum is clamped to the signed `ACC_W`-bit range after every addition.
- R7: An output appears exactly `LAT` cycles after the cycle in which its pair was taken. In final mode, that pair is the one at index `N_NEUR-1`.
- R8: With `cfg_we`=1, `cfg_sel`=0 writes the low `SAMP_W+1` bits of `cfg_data` as the bias of neuron `cfg_addr`. `cfg_sel`=1 writes the low `WGT_W` bits as that neuron's output weight. The new value takes effect for pairs taken afterwards.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears the pipeline, the neuron index and the accumulator. After it, `out_valid` is low and a new vector starts at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| final_mode | input | 1 | 0: rectified hidden outputs, 1: single weighted sum; hold for a whole vector |
| pos_valid | input | 1 | Positive-array sample present |
| pos_data | input | SAMP_W | Positive-array converter code |
| pos_ready | output | 1 | Positive sample taken this cycle when valid |
| neg_valid | input | 1 | Negative-array sample present |
| neg_data | input | SAMP_W | Negative-array converter code |
| neg_ready | output | 1 | Negative sample taken this cycle when valid |
| cfg_we | input | 1 | Register-file write enable |
| cfg_sel | input | 1 | 0: bias file, 1: output-weight file |
| cfg_addr | input | $clog2(N_NEUR) | Neuron index to write |
| cfg_data | input | max(SAMP_W+1, WGT_W) | Write value (signed, low bits used) |
| out_valid | output | 1 | Output word present |
| out_last | output | 1 | Last output of the vector |
| out_data | output | ACC_W | Signed result |

## Verification
On every cycle, the embedded assertions check several properties. Each stage-1 capture must trace back to a cycle with both valids high, and each difference must stay inside the range the sample width allows. The neuron index must wrap after the last neuron, the accumulator must not move without a final-mode input, and a final-mode output must carry last. Hidden outputs must never be negative. Only the bench's scenarios show the arithmetic values, the clamping at both accumulator limits, the exact `LAT`-cycle spacing, and the effect of register-file writes and of a reset in the middle of a vector. The bench sweeps every pair of 4-bit codes against a spread of biases to obtain them.

// File: rtl/xdp_pkg.sv
// Package: shared selector encoding for the register-file write port.
// Assumes: nothing beyond IEEE 1800-2017.
package xdp_pkg;
    typedef enum logic {
        CFG_BIAS   = 1'b0,
        CFG_WEIGHT = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/xdp_pair_in.sv
// Pair intake: joins the two converter streams, forms the signed
// positive-minus-negative difference and tracks the neuron index.
// Assumes: samples are unsigned codes; a pair is taken only when both
// streams are valid, so each stream's ready mirrors the other's valid.
module xdp_pair_in #(
    parameter int N_NEUR = 48,
    parameter int SAMP_W = 10,
    parameter int IDX_W  = 6,
    parameter int DIFF_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     final_mode,
    input  logic                     pos_valid,
    input  logic [SAMP_W-1:0]        pos_data,
    input  logic                     neg_valid,
    input  logic [SAMP_W-1:0]        neg_data,
    output logic                     pos_ready,
    output logic                     neg_ready,
    output logic                     s1_valid,
    output logic [IDX_W-1:0]         s1_idx,
    output logic                     s1_final,
    output logic signed [DIFF_W-1:0] s1_diff
);
    localparam logic [IDX_W-1:0]         LAST_IDX = IDX_W'(N_NEUR - 1);
    localparam logic signed [DIFF_W-1:0] MAX_MAG  = DIFF_W'((1 << SAMP_W) - 1);

    logic             take;
    logic [IDX_W-1:0] idx;

    // Handshake: a stream may only advance together with its partner.
    always_comb begin
        take      = pos_valid && neg_valid;
        pos_ready = neg_valid;
        neg_ready = pos_valid;
    end

    // Stage 1 register and neuron index counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_final <= 1'b0;
            s1_diff  <= '0;
        end else begin
            s1_valid <= take;
            if (take) begin
                s1_idx   <= idx;
                s1_final <= final_mode;
                s1_diff  <= $signed({1'b0, pos_data}) - $signed({1'b0, neg_data});
                idx      <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
            end
        end
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && idx == LAST_IDX) |=> (idx == '0)); // R5

    AST_DIFF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_diff <= MAX_MAG && s1_diff >= -MAX_MAG)); // R2
endmodule

// File: rtl/xdp_act_stage.sv
// Activation stage: adds the neuron bias to the difference, clamps the
// sum to the difference width and rectifies it.
// Assumes: bias has the same signed width as the difference.
module xdp_act_stage #(
    parameter int IDX_W  = 6,
    parameter int DIFF_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic [IDX_W-1:0]         s1_idx,
    input  logic                     s1_final,
    input  logic signed [DIFF_W-1:0] s1_diff,
    input  logic signed [DIFF_W-1:0] bias,
    output logic                     s2_valid,
    output logic [IDX_W-1:0]         s2_idx,
    output logic                     s2_final,
    output logic signed [DIFF_W-1:0] s2_act
);
    localparam logic signed [DIFF_W:0] HI = (DIFF_W+1)'((1 << (DIFF_W - 1)) - 1);
    localparam logic signed [DIFF_W:0] LO = -(DIFF_W+1)'(1 << (DIFF_W - 1));

    logic signed [DIFF_W:0]   wide_sum;
    logic signed [DIFF_W-1:0] clamped;
    logic signed [DIFF_W-1:0] rect;

    // Bias add with one guard bit, clamp, then rectifier.
    always_comb begin
        wide_sum = $signed({s1_diff[DIFF_W-1], s1_diff}) + $signed({bias[DIFF_W-1], bias});
        if (wide_sum > HI)      clamped = HI[DIFF_W-1:0];
        else if (wide_sum < LO) clamped = LO[DIFF_W-1:0];
        else                    clamped = wide_sum[DIFF_W-1:0];
        rect = clamped[DIFF_W-1] ? '0 : clamped;
    end

    // Stage 2 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_idx   <= '0;
            s2_final <= 1'b0;
            s2_act   <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_idx   <= s1_idx;
                s2_final <= s1_final;
                s2_act   <= rect;
            end
        end
    end
endmodule

// File: rtl/xdp_final_acc.sv
// Output stage: in hidden mode passes the rectified value through; in
// final mode multiplies it by the output weight and accumulates the
// products with saturation, emitting one sum at the last neuron.
// Assumes: ACC_W >= DIFF_W; mode is constant across a vector.
module xdp_final_acc #(
    parameter int N_NEUR = 48,
    parameter int IDX_W  = 6,
    parameter int DIFF_W = 11,
    parameter int WGT_W  = 8,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s2_valid,
    input  logic [IDX_W-1:0]         s2_idx,
    input  logic                     s2_final,
    input  logic signed [DIFF_W-1:0] s2_act,
    input  logic signed [WGT_W-1:0]  wgt,
    output logic                     s4_valid,
    output logic                     s4_last,
    output logic                     s4_final,
    output logic signed [ACC_W-1:0]  s4_data
);
    localparam int PROD_W = DIFF_W + WGT_W;
    localparam int SUM_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
    localparam logic [IDX_W-1:0]       LAST_IDX = IDX_W'(N_NEUR - 1);
    localparam logic signed [SUM_W-1:0] ACC_HI = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] ACC_LO = -SUM_W'(64'sd1 <<< (ACC_W - 1));

    logic                     s3_valid, s3_final, s3_first, s3_last;
    logic signed [PROD_W-1:0] s3_val;
    logic signed [ACC_W-1:0]  acc;
    logic signed [SUM_W-1:0]  base_w, val_w, sum_w;
    logic signed [ACC_W-1:0]  sum_sat;

    // Stage 3: product in final mode, sign-extended value in hidden mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
            s3_final <= 1'b0;
            s3_first <= 1'b0;
            s3_last  <= 1'b0;
            s3_val   <= '0;
        end else begin
            s3_valid <= s2_valid;
            if (s2_valid) begin
                s3_final <= s2_final;
                s3_first <= (s2_idx == '0);
                s3_last  <= (s2_idx == LAST_IDX);
                s3_val   <= s2_final ? PROD_W'(s2_act * wgt)
                                     : {{WGT_W{s2_act[DIFF_W-1]}}, s2_act};
            end
        end
    end

    // Saturating sum of the running total (or zero on neuron 0) and the product.
    always_comb begin
        base_w = s3_first ? '0 : {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
        val_w  = {{(SUM_W-PROD_W){s3_val[PROD_W-1]}}, s3_val};
        sum_w  = base_w + val_w;
        if (sum_w > ACC_HI)      sum_sat = ACC_HI[ACC_W-1:0];
        else if (sum_w < ACC_LO) sum_sat = ACC_LO[ACC_W-1:0];
        else                     sum_sat = sum_w[ACC_W-1:0];
    end

    // Stage 4: accumulator update and output word formation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            s4_valid <= 1'b0;
            s4_last  <= 1'b0;
            s4_final <= 1'b0;
            s4_data  <= '0;
        end else begin
            s4_valid <= s3_valid && (!s3_final || s3_last);
            s4_last  <= s3_valid && s3_last;
            s4_final <= s3_valid && s3_final;
            if (s3_valid && s3_final) begin
                acc     <= sum_sat;
                s4_data <= sum_sat;
            end else if (s3_valid) begin
                s4_data <= val_w[ACC_W-1:0];
            end
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(s3_valid && s3_final) |=> $stable(acc)); // R6
endmodule

// File: rtl/xdp_delay.sv
// Delay line: pads the compute pipeline up to the fixed total latency.
// Assumes: DEPTH >= 0; depth 0 is a plain wire.
module xdp_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] pipe [DEPTH];
            // Shift register, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign dout = pipe[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/xbar_diff_post.sv
// Top: differential crossbar layer post-processor. Pairs the two
// converter streams, subtracts, biases, rectifies, and either streams
// the hidden results or reduces them to one weighted sum.
// Assumes: LAT >= 4, ACC_W >= SAMP_W+1, register files loaded before use,
// final_mode held constant for a whole vector.
module xbar_diff_post #(
    parameter int N_NEUR = 48,
    parameter int SAMP_W = 10,
    parameter int WGT_W  = 8,
    parameter int ACC_W  = 20,
    parameter int LAT    = 10,
    localparam int IDX_W  = $clog2(N_NEUR),
    localparam int DIFF_W = SAMP_W + 1,
    localparam int CFG_W  = (DIFF_W > WGT_W) ? DIFF_W : WGT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              final_mode,
    input  logic              pos_valid,
    input  logic [SAMP_W-1:0] pos_data,
    output logic              pos_ready,
    input  logic              neg_valid,
    input  logic [SAMP_W-1:0] neg_data,
    output logic              neg_ready,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [ACC_W-1:0]  out_data
);
    import xdp_pkg::*;

    localparam int STAGES = 4;
    localparam int DLY    = LAT - STAGES;
    localparam int OUT_BUS = ACC_W + 3;

    logic signed [DIFF_W-1:0] bias_rf [N_NEUR];
    logic signed [WGT_W-1:0]  wgt_rf  [N_NEUR];

    logic                     s1_valid, s1_final, s2_valid, s2_final;
    logic [IDX_W-1:0]         s1_idx, s2_idx;
    logic signed [DIFF_W-1:0] s1_diff, s2_act;
    logic                     s4_valid, s4_last, s4_final, out_final;
    logic signed [ACC_W-1:0]  s4_data;
    logic [OUT_BUS-1:0]       bus_in, bus_out;

    // Register files: bias and output weight per neuron.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_NEUR; i++) begin
                bias_rf[i] <= '0;
                wgt_rf[i]  <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_sel == CFG_BIAS) bias_rf[cfg_addr] <= cfg_data[DIFF_W-1:0];
            else                     wgt_rf[cfg_addr]  <= cfg_data[WGT_W-1:0];
        end
    end

    xdp_pair_in #(
        .N_NEUR (N_NEUR),
        .SAMP_W (SAMP_W),
        .IDX_W  (IDX_W),
        .DIFF_W (DIFF_W)
    ) i_pair_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .final_mode (final_mode),
        .pos_valid  (pos_valid),
        .pos_data   (pos_data),
        .neg_valid  (neg_valid),
        .neg_data   (neg_data),
        .pos_ready  (pos_ready),
        .neg_ready  (neg_ready),
        .s1_valid   (s1_valid),
        .s1_idx     (s1_idx),
        .s1_final   (s1_final),
        .s1_diff    (s1_diff)
    );

    xdp_act_stage #(
        .IDX_W  (IDX_W),
        .DIFF_W (DIFF_W)
    ) i_act_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_idx   (s1_idx),
        .s1_final (s1_final),
        .s1_diff  (s1_diff),
        .bias     (bias_rf[s1_idx]),
        .s2_valid (s2_valid),
        .s2_idx   (s2_idx),
        .s2_final (s2_final),
        .s2_act   (s2_act)
    );

    xdp_final_acc #(
        .N_NEUR (N_NEUR),
        .IDX_W  (IDX_W),
        .DIFF_W (DIFF_W),
        .WGT_W  (WGT_W),
        .ACC_W  (ACC_W)
    ) i_final_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .s2_valid (s2_valid),
        .s2_idx   (s2_idx),
        .s2_final (s2_final),
        .s2_act   (s2_act),
        .wgt      (wgt_rf[s2_idx]),
        .s4_valid (s4_valid),
        .s4_last  (s4_last),
        .s4_final (s4_final),
        .s4_data  (s4_data)
    );

    // Pack the stage-4 word for the latency padding.
    assign bus_in = {s4_valid, s4_last, s4_final, s4_data};

    xdp_delay #(
        .W     (OUT_BUS),
        .DEPTH (DLY)
    ) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_in),
        .dout  (bus_out)
    );

    // Unpack the delayed word onto the output ports.
    assign {out_valid, out_last, out_final, out_data} = bus_out;

    AST_PAIR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(pos_valid && neg_valid)); // R1

    AST_HIDDEN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_final) |-> !out_data[ACC_W-1]); // R4

    AST_FINAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_final) |-> out_last); // R6
endmodule

// File: tb/test_xbar_diff_post.sv
// Bench: sweeps all 4-bit code pairs in hidden mode, then weighted sums
// including both clamp limits, and a reset in the middle of a vector.
module test_xbar_diff_post;
    localparam int N      = 48;
    localparam int SW     = 4;
    localparam int WW     = 5;
    localparam int AW     = 12;
    localparam int LAT    = 10;
    localparam int IW     = $clog2(N);
    localparam int CW     = 5;
    localparam int D_HI   = 15;
    localparam int D_LO   = -16;
    localparam int A_HI   = 2047;
    localparam int A_LO   = -2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          final_mode = 1'b0;
    logic          pos_valid = 1'b0, neg_valid = 1'b0;
    logic [SW-1:0] pos_data = '0, neg_data = '0;
    logic          pos_ready, neg_ready;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_data = '0;
    logic          out_valid, out_last;
    logic [AW-1:0] out_data;

    xbar_diff_post #(.N_NEUR(N), .SAMP_W(SW), .WGT_W(WW), .ACC_W(AW), .LAT(LAT)) i_xbar_diff_post (
        .clk(clk), .rst_n(rst_n), .final_mode(final_mode),
        .pos_valid(pos_valid), .pos_data(pos_data), .pos_ready(pos_ready),
        .neg_valid(neg_valid), .neg_data(neg_data), .neg_ready(neg_ready),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int bias_m [N];
    int wgt_m  [N];
    int m_idx = 0, m_acc = 0;
    int exp_d [600], exp_c [600];
    bit exp_l [600];
    string exp_t [600];
    int exp_n = 0;
    int got_d [600], got_c [600];
    bit got_l [600];
    int got_n = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && got_n < 600) begin
            got_d[got_n] = int'($signed(out_data));
            got_l[got_n] = out_last;
            got_c[got_n] = cyc;
            got_n++;
        end
    end

    task automatic write_cfg(input bit sel, input int addr, input int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = IW'(addr); cfg_data = CW'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Drive one pair; lead 1: positive first, 2: negative first. Models R2-R7.
    task automatic send(input int p, input int q, input int lead);
        int a;
        if (lead == 1) begin
            pos_valid = 1'b1; pos_data = SW'(p);
            @(negedge clk);
            chk(pos_ready == 1'b0, "R1 pos stalled", int'(pos_ready), 0);
            @(posedge clk); #1;
        end else if (lead == 2) begin
            neg_valid = 1'b1; neg_data = SW'(q);
            @(negedge clk);
            chk(neg_ready == 1'b0, "R1 neg stalled", int'(neg_ready), 0);
            @(posedge clk); #1;
        end
        pos_valid = 1'b1; pos_data = SW'(p);
        neg_valid = 1'b1; neg_data = SW'(q);
        a = clampi(p - q + bias_m[m_idx], D_LO, D_HI);
        if (a < 0) a = 0;
        if (!final_mode) begin
            exp_d[exp_n] = a; exp_l[exp_n] = (m_idx == N-1); exp_c[exp_n] = cyc + LAT;
            exp_t[exp_n] = "R2 R3 R4 R5 hidden"; exp_n++;
        end else begin
            m_acc = clampi(((m_idx == 0) ? 0 : m_acc) + a * wgt_m[m_idx], A_LO, A_HI);
            if (m_idx == N-1) begin
                exp_d[exp_n] = m_acc; exp_l[exp_n] = 1'b1; exp_c[exp_n] = cyc + LAT;
                exp_t[exp_n] = "R6 final sum"; exp_n++;
            end
        end
        m_idx = (m_idx == N-1) ? 0 : m_idx + 1;
        @(posedge clk); #1;
        pos_valid = 1'b0; neg_valid = 1'b0;
    endtask

    // Drain and compare one phase, then clear the logs.
    task automatic compare_phase();
        repeat (LAT + 4) @(posedge clk);
        #1;
        chk(got_n == exp_n, "R5 R6 output count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_d[i] == exp_d[i], exp_t[i], got_d[i], exp_d[i]);
            chk(got_l[i] == exp_l[i], "R5 R6 last flag", int'(got_l[i]), int'(exp_l[i]));
            chk(got_c[i] == exp_c[i], "R7 latency", got_c[i], exp_c[i]);
        end
        exp_n = 0; got_n = 0;
    endtask

    task automatic print_summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pos_ready == 1'b0 && neg_ready == 1'b0, "R1 idle readies",
            int'({pos_ready, neg_ready}), 0);
        @(posedge clk); #1;

        // R8: biases spread over the full signed range.
        for (int n = 0; n < N; n++) begin
            bias_m[n] = (n % 32) - 16;
            write_cfg(1'b0, n, bias_m[n]);
        end
        // Hidden sweep: every positive/negative code pair.
        final_mode = 1'b0;
        for (int i = 0; i < 288; i++) begin
            if (i < 256) send(i % 16, i / 16, i % 3);
            else         send(i % 16, i % 16, i % 3);
        end
        compare_phase();

        // R6 R8: mixed weighted sum.
        for (int n = 0; n < N; n++) begin
            wgt_m[n] = ((n * 7) % 32) - 16;
            write_cfg(1'b1, n, wgt_m[n]);
        end
        final_mode = 1'b1;
        for (int n = 0; n < N; n++) send((n * 5) % 16, (n * 3) % 16, n % 3);
        compare_phase();

        // R3 R6: upper clamp (bias saturates, sum saturates high).
        for (int n = 0; n < N; n++) begin
            bias_m[n] = 15; write_cfg(1'b0, n, 15);
            wgt_m[n] = 15;  write_cfg(1'b1, n, 15);
        end
        for (int n = 0; n < N; n++) send(15, 0, 0);
        compare_phase();

        // R6: lower clamp.
        for (int n = 0; n < N; n++) begin
            wgt_m[n] = -16; write_cfg(1'b1, n, -16);
        end
        for (int n = 0; n < N; n++) send(15, 0, 0);
        compare_phase();

        // R9: reset in the middle of a final-mode vector.
        for (int n = 0; n < 20; n++) send(15, 0, 0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R9 reset mid-vector", int'(out_valid), 0);
        rst_n = 1'b1;
        m_idx = 0; m_acc = 0; exp_n = 0; got_n = 0;
        for (int n = 0; n < N; n++) begin
            bias_m[n] = 0; write_cfg(1'b0, n, 0);
            wgt_m[n] = (n % 2 == 0) ? 3 : -2; write_cfg(1'b1, n, wgt_m[n]);
        end
        for (int n = 0; n < N; n++) send(n % 16, 2, n % 3);
        compare_phase();

        done = 1'b1;
        print_summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            print_summary();
            $finish;
        end
    end
endmodule